// File: doc/BRIEF.md
# PLL Lock Timer and Configuration Register

This block holds the control state of a clock synthesizer: a configuration word with a feedback multiplier (M), a pre-divider (P) and a post-scaler (S), and a lock-time setting. A plain single-cycle register bus writes and reads both registers. The active M, P and S values drive the synthesizer, and a lock flag tells consumers when the output clock may be used.

Changing M or P disturbs the loop, so the flag drops and a down-counter loaded with the lock time must expire before the flag returns. Changing S alone only rescales an already stable output and leaves the flag and any running count untouched. The lock time comes either from a programmed cycle count or, in auto mode, from the new pre-divider multiplied by a per-step constant (250 by default). The count in use is captured when the relock starts, so software may reprogram the lock time at any moment.

Top module: `pll_lock_ctrl`

## Requirements
- R1: After reset, the lock flag is 0, M, P and S outputs are 0, and both registers read back as 0.
- R2: A write to address 0 updates the outputs on the next clock edge, taking M from bits [25:16], P from bits [13:8] and S from bits [2:0]; all other written bits are ignored.
- R3: A write to address 0 whose M or P differs from the active value clears the lock flag at that edge; with a lock count of N the flag reads 1 from the (N+1)-th edge after the write edge.
- R4: With a lock count of zero, the lock flag is 1 from the first edge after the configuration write.
- R5: A configuration write with M and P unchanged updates S only and does not restart the count: a set lock flag stays 1 and a running count keeps its schedule.
- R6: A write to the lock-time register during a count does not alter that count; the new value applies from the next M or P change.
- R7: When bit 31 of the lock-time register is 1 (auto mode), an M or P change loads a count of the new P times 250 instead of the programmed count.
- R8: Reading address 0 returns M, P and S at their write positions, the live lock flag at bit 29 and 0 elsewhere, on the edge after the read request.
- R9: Reading address 1 returns the programmed count in bits [19:0] and the auto bit in bit 31, with 0 elsewhere.
- R10: An M or P change that arrives while a count runs, including on the edge at which the count would complete, keeps the flag at 0 and starts a fresh count from that write.
- R11: Writes to addresses other than 0 and 1 change no output and no register; such reads return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address (0 config, 1 lock time) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| m_out | output | 10 | Active feedback multiplier |
| p_out | output | 6 | Active pre-divider |
| s_out | output | 3 | Active post-scaler |
| locked | output | 1 | Lock flag |

## Verification
The counter reaching zero and a new M or P write can meet on the same edge, where completion and restart compete for the lock flag. The bench times a second configuration write to land exactly on the edge where the first count would finish, then judges that the flag stays 0 and rises only a full fresh count later. It also lands a lock-time write inside a running count to show the running schedule is kept while the next change uses the new value.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;
  // Field placement in the configuration word; software depends on these.
  localparam int M_LSB    = 16;
  localparam int P_LSB    = 8;
  localparam int S_LSB    = 0;
  localparam int LOCK_BIT = 29;
  // Mode bit in the lock-time register.
  localparam int AUTO_BIT = 31;
  // Register addresses.
  localparam int ADDR_CFG  = 0;
  localparam int ADDR_LOCK = 1;
endpackage

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
  import pll_lock_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int M_W       = 10,
  parameter int P_W       = 6,
  parameter int S_W       = 3,
  parameter int CNT_W     = 20,
  parameter int CYC_PER_P = 250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              locked,
  output logic [M_W-1:0]    m_q,
  output logic [P_W-1:0]    p_q,
  output logic [S_W-1:0]    s_q,
  output logic              restart,
  output logic [CNT_W-1:0]  load_val,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [CNT_W-1:0] SCALE = CNT_W'(CYC_PER_P);

  logic             cfg_hit, lock_hit;
  logic [M_W-1:0]   new_m;
  logic [P_W-1:0]   new_p;
  logic [S_W-1:0]   new_s;
  logic [CNT_W-1:0] lock_q;
  logic             auto_q;
  logic [DATA_W-1:0] cfg_view, lock_view, rd_mux;

  assign cfg_hit  = wr_en && (addr == ADDR_W'(ADDR_CFG));
  assign lock_hit = wr_en && (addr == ADDR_W'(ADDR_LOCK));
  assign new_m    = wdata[M_LSB +: M_W];
  assign new_p    = wdata[P_LSB +: P_W];
  assign new_s    = wdata[S_LSB +: S_W];

  // Relock only when the loop-shaping fields move.
  assign restart  = cfg_hit && ((new_m != m_q) || (new_p != p_q));

  // Count snapshot taken at restart time.
  always_comb begin
    if (auto_q) load_val = {{(CNT_W-P_W){1'b0}}, new_p} * SCALE;
    else        load_val = lock_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_q <= '0;
      p_q <= '0;
      s_q <= '0;
    end else if (cfg_hit) begin
      m_q <= new_m;
      p_q <= new_p;
      s_q <= new_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= '0;
      auto_q <= 1'b0;
    end else if (lock_hit) begin
      lock_q <= wdata[CNT_W-1:0];
      auto_q <= wdata[AUTO_BIT];
    end
  end

  always_comb begin
    cfg_view = '0;
    cfg_view[M_LSB +: M_W] = m_q;
    cfg_view[P_LSB +: P_W] = p_q;
    cfg_view[S_LSB +: S_W] = s_q;
    cfg_view[LOCK_BIT]     = locked;
    lock_view = '0;
    lock_view[CNT_W-1:0]   = lock_q;
    lock_view[AUTO_BIT]    = auto_q;
    if (addr == ADDR_W'(ADDR_CFG))       rd_mux = cfg_view;
    else if (addr == ADDR_W'(ADDR_LOCK)) rd_mux = lock_view;
    else                                 rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/pll_lock_counter.sv
module pll_lock_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [CNT_W-1:0] load_val,
  output logic             locked,
  output logic             busy,
  output logic             cnt_zero
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy   <= 1'b0;
      locked <= 1'b0;
    end else if (restart) begin
      // A new M/P value always wins over a completing count.
      cnt_q  <= load_val;
      busy   <= 1'b1;
      locked <= 1'b0;
    end else if (busy) begin
      if (cnt_zero) begin
        busy   <= 1'b0;
        locked <= 1'b1;
      end else begin
        cnt_q  <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pll_lock_ctrl.sv
module pll_lock_ctrl #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int M_W       = 10,
  parameter int P_W       = 6,
  parameter int S_W       = 3,
  parameter int CNT_W     = 20,
  parameter int CYC_PER_P = 250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [M_W-1:0]    m_out,
  output logic [P_W-1:0]    p_out,
  output logic [S_W-1:0]    s_out,
  output logic              locked
);
  logic             wr_en, rd_en;
  logic             restart;
  logic [CNT_W-1:0] load_val;
  logic             tmr_busy, tmr_zero;

  assign wr_en = bus_sel && bus_we;
  assign rd_en = bus_sel && !bus_we;

  pll_cfg_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .M_W(M_W), .P_W(P_W), .S_W(S_W),
    .CNT_W(CNT_W), .CYC_PER_P(CYC_PER_P)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(bus_addr),
    .wdata(bus_wdata), .locked(locked), .m_q(m_out), .p_q(p_out), .s_q(s_out),
    .restart(restart), .load_val(load_val), .rdata(bus_rdata)
  );

  pll_lock_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .restart(restart), .load_val(load_val),
    .locked(locked), .busy(tmr_busy), .cnt_zero(tmr_zero)
  );
endmodule

// File: rtl/pll_lock_ctrl_chk.sv
module pll_lock_ctrl_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int M_W    = 10,
  parameter int P_W    = 6,
  parameter int S_W    = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [M_W-1:0]    m_out,
  input logic [P_W-1:0]    p_out,
  input logic [S_W-1:0]    s_out,
  input logic              locked,
  input logic              restart,
  input logic              tmr_busy,
  input logic              tmr_zero
);
  logic cfg_wr, same_mp, odd_wr;
  assign cfg_wr  = bus_sel && bus_we && (bus_addr == ADDR_W'(0));
  assign odd_wr  = bus_sel && bus_we && (bus_addr > ADDR_W'(1));
  assign same_mp = (bus_wdata[16 +: M_W] == m_out) && (bus_wdata[8 +: P_W] == p_out);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!locked && m_out == '0 && p_out == '0 && s_out == '0));

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> ($stable(m_out) && $stable(p_out) && $stable(s_out)));

  // R3
  restart_clears_lock_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> !locked);

  // R4
  lock_rise_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(tmr_busy && tmr_zero && !restart));

  // R5
  s_only_keeps_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && same_mp) |=> !$fell(locked));

  // R10
  restart_beats_expiry_chk: assert property (@(posedge clk) disable iff (rst)
    (restart && tmr_busy && tmr_zero) |=> (!locked && tmr_busy));

  // R11
  unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
    odd_wr |=> ($stable(m_out) && $stable(p_out) && $stable(locked)));
endmodule

bind pll_lock_ctrl pll_lock_ctrl_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .M_W(M_W), .P_W(P_W), .S_W(S_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .m_out(m_out), .p_out(p_out), .s_out(s_out),
  .locked(locked), .restart(restart), .tmr_busy(tmr_busy), .tmr_zero(tmr_zero)
);

// File: tb/pll_lock_ctrl_test.sv
module pll_lock_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [9:0]  m_out;
  logic [5:0]  p_out;
  logic [2:0]  s_out;
  logic        locked;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pll_lock_ctrl uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .m_out(m_out), .p_out(p_out),
    .s_out(s_out), .locked(locked)
  );

  // {lock-time word, config word, relock expected}
  localparam logic [64:0] VEC [8] = '{
    {32'h0000_0005, 32'h0145_0600, 1'b1},
    {32'h0000_0003, 32'h0145_0602, 1'b0},
    {32'h0000_0000, 32'h00C8_0602, 1'b1},
    {32'h0000_0004, 32'h00C8_0402, 1'b1},
    {32'h0000_0007, 32'hFCC8_C4FA, 1'b0},
    {32'h8000_0000, 32'h0064_0301, 1'b1},
    {32'h0000_0002, 32'h0064_0305, 1'b0},
    {32'h0000_0001, 32'h03FF_3F07, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] outs_word();
    return {6'b0, m_out, 2'b0, p_out, 5'b0, s_out};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 locked", {31'b0, locked}, 32'd0);
    chk("R1 outs", outs_word(), 32'd0);
    bus_read(2'd0, rd); chk("R1 cfg readback", rd, 32'd0);
    bus_read(2'd1, rd); chk("R1 lock readback", rd, 32'd0);
    // R5 unchanged all-zero config does not start a lock
    bus_write(2'd0, 32'h0000_0000);
    repeat (3) @(negedge clk);
    chk("R5 zero write keeps unlocked", {31'b0, locked}, 32'd0);

    // Vector table: R2, R3, R4, R5, R7
    for (int i = 0; i < 8; i++) begin
      logic [31:0] lw, cw;
      int n;
      lw = VEC[i][64:33];
      cw = VEC[i][32:1];
      bus_write(2'd1, lw);
      bus_write(2'd0, cw);
      chk("R2 fields", outs_word(), cw & 32'h03FF_3F07);
      if (VEC[i][0]) begin
        n = lw[31] ? int'(cw[13:8]) * 250 : int'(lw[19:0]);
        chk("R3 cleared on change", {31'b0, locked}, 32'd0);
        repeat (n) @(negedge clk);
        chk(lw[31] ? "R7 auto still counting" : "R3 still counting", {31'b0, locked}, 32'd0);
        @(negedge clk);
        chk(lw[31] ? "R7 auto lock" : (n == 0 ? "R4 zero count lock" : "R3 lock"),
            {31'b0, locked}, 32'd1);
      end else begin
        chk("R5 s-only keeps lock", {31'b0, locked}, 32'd1);
        @(negedge clk);
        chk("R5 s-only keeps lock later", {31'b0, locked}, 32'd1);
      end
    end

    // R8 readback while locked
    bus_read(2'd0, rd); chk("R8 cfg readback locked", rd, 32'h23FF_3F07);

    // R9 lock-time readback masking
    bus_write(2'd1, 32'hFFFF_FFFF);
    bus_read(2'd1, rd); chk("R9 lock readback", rd, 32'h800F_FFFF);
    bus_write(2'd1, 32'h0000_0123);
    bus_read(2'd1, rd); chk("R9 lock readback plain", rd, 32'h0000_0123);

    // R6 lock-time write during a count
    bus_write(2'd1, 32'd10);
    bus_write(2'd0, 32'h0010_0101);
    repeat (2) @(negedge clk);
    bus_write(2'd1, 32'd3);
    repeat (7) @(negedge clk);
    chk("R6 old count kept", {31'b0, locked}, 32'd0);
    @(negedge clk);
    chk("R6 old count done", {31'b0, locked}, 32'd1);
    bus_write(2'd0, 32'h0011_0101);
    repeat (3) @(negedge clk);
    chk("R6 new count running", {31'b0, locked}, 32'd0);
    @(negedge clk);
    chk("R6 new count done", {31'b0, locked}, 32'd1);

    // R10 restart in mid-count
    bus_write(2'd1, 32'd6);
    bus_write(2'd0, 32'h0012_0101);
    repeat (3) @(negedge clk);
    bus_write(2'd0, 32'h0013_0101);
    bus_read(2'd0, rd); chk("R8 cfg readback counting", rd, 32'h0013_0101);
    repeat (5) @(negedge clk);
    chk("R10 mid restart still counting", {31'b0, locked}, 32'd0);
    @(negedge clk);
    chk("R10 mid restart lock", {31'b0, locked}, 32'd1);

    // R10 restart on the completing edge
    bus_write(2'd1, 32'd4);
    bus_write(2'd0, 32'h0014_0101);
    repeat (4) @(negedge clk);
    bus_write(2'd0, 32'h0015_0101);
    chk("R10 restart wins at expiry", {31'b0, locked}, 32'd0);
    repeat (4) @(negedge clk);
    chk("R10 fresh count running", {31'b0, locked}, 32'd0);
    @(negedge clk);
    chk("R10 fresh count lock", {31'b0, locked}, 32'd1);

    // R11 unmapped address
    bus_write(2'd2, 32'h03FF_3F07);
    chk("R11 outs unchanged", outs_word(), 32'h0015_0101);
    chk("R11 lock unchanged", {31'b0, locked}, 32'd1);
    bus_read(2'd2, rd); chk("R11 unmapped read", rd, 32'd0);
    bus_read(2'd1, rd); chk("R11 lock reg unchanged", rd, 32'd4);

    // R1 reset in operation
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset again locked", {31'b0, locked}, 32'd0);
    chk("R1 reset again outs", outs_word(), 32'd0);
    bus_read(2'd1, rd); chk("R1 reset again lock reg", rd, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule